// File: doc/BRIEF.md
# Descriptor Ring Producer with Lap Stamping

This block fills a circular descriptor ring from the producing side. Each accepted entry goes out on a storage write port at the slot given by the head index, and the head then moves one slot forward. A 4-bit pass counter is written into the top bits of every entry. A consumer can therefore tell fresh slots from stale ones by the parity of that counter alone, and never has to read the head pointer.

The consumer returns its position through a tail-update port. The block compares head and tail to detect a full ring and holds input ready low while the ring is full. One cycle after each storage write, a single-cycle interrupt pulse tells downstream logic that new entries are present. An entry whose internal-error flag is set carries an error code in the counter field, so it is stored exactly as received.

Top module: `ring_producer`

## Requirements
- R1: After reset, head_idx is 0, full is 0, in_ready is 1, wr_en is 0, irq is 0, and the internal pass counter is 0.
- R2: When in_valid and in_ready are both high at a clock edge, wr_en is high for the following cycle with wr_addr equal to the head index before that edge. At the same edge head_idx advances by one modulo DEPTH.
- R3: full is high exactly when (head_idx + 1) mod DEPTH equals the stored tail index. in_ready is the inverse of full. An entry offered while full produces no storage write.
- R4: A tail_we pulse loads tail_idx into the stored tail index. The new value affects full and in_ready from the next cycle, not the cycle of the update.
- R5: For an entry without the error flag, bits [ENTRY_W-1:ENTRY_W-4] (bits [31:28] of the last 32-bit word) are replaced by the stamp. The stamp equals the pass counter plus one modulo 16, so entries written on the first pass around the ring carry 1.
- R6: The pass counter increments by one at the edge where an accepted write moves the head from DEPTH-1 back to 0, and is unchanged at every other edge. After 15 it continues at 0, so the stamp cycles 1..15, 0, 1 and so on.
- R7: An entry whose error flag (entry bit ERR_POS, default 31: bit 31 of word 0) is 1 is written with all bits unchanged, including the counter field. It still advances the head and the pass counter in the normal way.
- R8: irq is high for one cycle immediately after each cycle in which wr_en is high, and is low otherwise.
- R9: For an entry without the error flag, all bits below the counter field reach wr_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry can be accepted (ring not full) |
| in_data | input | ENTRY_W | Entry payload, word 0 in the low bits |
| tail_we | input | 1 | Load a new consumer tail index |
| tail_idx | input | IDX_W | Consumer tail index |
| wr_en | output | 1 | Storage write strobe |
| wr_addr | output | IDX_W | Storage slot being written |
| wr_data | output | ENTRY_W | Stamped entry |
| head_idx | output | IDX_W | Next slot the producer will fill |
| full | output | 1 | Ring holds DEPTH-1 unconsumed entries |
| irq | output | 1 | One-cycle pulse after each storage write |

## Verification
Two things can happen in the same cycle: a tail update and an entry offer while the ring is full. The ring is first filled against a fixed tail so that it goes full. The tail is then moved in the same cycle that an entry is offered. The expected result is that the offer is refused in that cycle and accepted in the next. A further case is a head wrap that coincides with an error-flagged entry. This entry must pass through unchanged while the pass counter still advances, and the stamp on the next clean entry shows whether it did. Random offers, tail moves and error flags run for enough passes to take the counter through its 15-to-0 wrap.

// File: rtl/ring_prod_pkg.sv
package ring_prod_pkg;

  localparam int LAP_W = 4;

  typedef logic [LAP_W-1:0] lap_t;

  // Stamp written into an entry: pass counter plus one, wrapping.
  function automatic lap_t stamp_of(input lap_t pass_cnt);
    return pass_cnt + lap_t'(1);
  endfunction

endpackage

// File: rtl/ring_idx_ctrl.sv
module ring_idx_ctrl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             tail_we_i,
  input  logic [IDX_W-1:0] tail_i,
  output logic [IDX_W-1:0] head_o,
  output logic             full_o,
  output logic             wrap_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam bit               IS_POW2  = (DEPTH == (1 << IDX_W));

  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [IDX_W-1:0] head_inc;
  logic             at_last;

  assign at_last = (head_q == LAST_IDX);

  generate
    if (IS_POW2) begin : g_pow2
      assign head_inc = head_q + IDX_W'(1);
    end else begin : g_mod
      assign head_inc = at_last ? '0 : head_q + IDX_W'(1);
    end
  endgenerate

  always_comb begin
    head_d = head_q;
    if (push_i) begin
      head_d = head_inc;
    end
    tail_d = tail_q;
    if (tail_we_i) begin
      tail_d = tail_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o = head_q;
  assign full_o = (head_inc == tail_q);
  assign wrap_o = push_i && at_last;

  // R2
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_q <= LAST_IDX);

  // R2
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> head_q == (($past(head_q) == LAST_IDX) ? '0 : $past(head_q) + IDX_W'(1)));

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(head_q));

endmodule

// File: rtl/ring_lap_ctr.sv
module ring_lap_ctr
  import ring_prod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output lap_t lap_o
);

  lap_t lap_q, lap_d;

  always_comb begin
    lap_d = lap_q;
    if (wrap_i) begin
      lap_d = lap_q + lap_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lap_q <= '0;
    end else begin
      lap_q <= lap_d;
    end
  end

  assign lap_o = lap_q;

  // R6
  lap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(lap_q));

  // R6
  lap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> lap_q == $past(lap_q) + lap_t'(1));

endmodule

// File: rtl/ring_entry_stamp.sv
module ring_entry_stamp
  import ring_prod_pkg::*;
#(
  parameter int ENTRY_W   = 128,
  parameter int ERR_POS   = 31,
  parameter bit ERR_CHECK = 1'b1
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  lap_t               lap_i,
  output logic [ENTRY_W-1:0] entry_o
);

  localparam int FIELD_LSB = ENTRY_W - LAP_W;

  logic [ENTRY_W-1:0] stamped;
  logic               keep_raw;

  always_comb begin
    stamped = entry_i;
    stamped[ENTRY_W-1:FIELD_LSB] = stamp_of(lap_i);
  end

  generate
    if (ERR_CHECK) begin : g_err
      assign keep_raw = entry_i[ERR_POS];
    end else begin : g_noerr
      assign keep_raw = 1'b0;
    end
  endgenerate

  assign entry_o = keep_raw ? entry_i : stamped;

endmodule

// File: rtl/ring_producer.sv
module ring_producer
  import ring_prod_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ENTRY_WORDS = 4,
  parameter int WORD_W      = 32,
  parameter int ERR_POS     = 31,
  parameter int ENTRY_W     = ENTRY_WORDS * WORD_W,
  parameter int IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_data,
  input  logic               tail_we,
  input  logic [IDX_W-1:0]   tail_idx,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [ENTRY_W-1:0] wr_data,
  output logic [IDX_W-1:0]   head_idx,
  output logic               full,
  output logic               irq
);

  logic               accept;
  logic               wrap;
  logic               full_w;
  logic [IDX_W-1:0]   head_w;
  lap_t               lap_w;
  logic [ENTRY_W-1:0] stamped_w;

  logic               wr_en_q, wr_en_d;
  logic [IDX_W-1:0]   wr_addr_q;
  logic [ENTRY_W-1:0] wr_data_q;
  logic               irq_q, irq_d;

  assign accept = in_valid && !full_w;

  ring_idx_ctrl #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) idx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (accept),
    .tail_we_i (tail_we),
    .tail_i    (tail_idx),
    .head_o    (head_w),
    .full_o    (full_w),
    .wrap_o    (wrap)
  );

  ring_lap_ctr lap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap),
    .lap_o  (lap_w)
  );

  ring_entry_stamp #(
    .ENTRY_W   (ENTRY_W),
    .ERR_POS   (ERR_POS),
    .ERR_CHECK (1'b1)
  ) stamp_i (
    .entry_i (in_data),
    .lap_i   (lap_w),
    .entry_o (stamped_w)
  );

  always_comb begin
    wr_en_d = accept;
    irq_d   = wr_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      wr_en_q <= wr_en_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (accept) begin
      wr_addr_q <= head_w;
      wr_data_q <= stamped_w;
    end
  end

  assign in_ready = !full_w;
  assign full     = full_w;
  assign head_idx = head_w;
  assign wr_en    = wr_en_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
  assign irq      = irq_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> !wr_en);

  // R2
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (wr_en && wr_addr == $past(head_idx)));

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[ERR_POS]) |=> wr_data == $past(in_data));

  // R8
  irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> irq);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !irq);

endmodule

// File: tb/ring_producer_tb.sv
module ring_producer_tb_top;

  localparam int D   = 16;
  localparam int IW  = 4;
  localparam int EW  = 128;
  localparam int ERR = 31;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [EW-1:0] in_data;
  logic          tail_we;
  logic [IW-1:0] tail_idx;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [EW-1:0] wr_data;
  logic [IW-1:0] head_idx;
  logic          full;
  logic          irq;

  ring_producer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .tail_we  (tail_we),
    .tail_idx (tail_idx),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .head_idx (head_idx),
    .full     (full),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int            mh, mt, ml;
  bit            exp_wr, exp_irq;
  int            exp_addr;
  logic [EW-1:0] exp_data;
  bit            exp_err;

  function automatic logic [EW-1:0] stamp_fn(input logic [EW-1:0] d, input int lap);
    logic [EW-1:0] r;
    r = d;
    if (!d[ERR]) r[EW-1:EW-4] = 4'((lap + 1) % 16);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input logic [EW-1:0] d, input bit tw, input int tv);
    bit mfull;
    bit acc;
    @(negedge clk);
    mfull = (((mh + 1) % D) == mt);
    chk(head_idx == IW'(mh), "R2", "head_idx", EW'(head_idx), EW'(mh));
    chk(full == mfull, "R3", "full", EW'(full), EW'(mfull));
    chk(in_ready == !mfull, "R3", "in_ready", EW'(in_ready), EW'(!mfull));
    chk(wr_en == exp_wr, "R2", "wr_en", EW'(wr_en), EW'(exp_wr));
    if (exp_wr) begin
      chk(wr_addr == IW'(exp_addr), "R2", "wr_addr", EW'(wr_addr), EW'(exp_addr));
      if (exp_err) begin
        chk(wr_data == exp_data, "R7", "error entry", wr_data, exp_data);
      end else begin
        chk(wr_data[EW-1:EW-4] == exp_data[EW-1:EW-4], "R5",
            "stamp", EW'(wr_data[EW-1:EW-4]), EW'(exp_data[EW-1:EW-4]));
        chk(wr_data[EW-5:0] == exp_data[EW-5:0], "R9", "payload",
            EW'(wr_data[EW-5:0]), EW'(exp_data[EW-5:0]));
      end
    end
    chk(irq == exp_irq, "R8", "irq", EW'(irq), EW'(exp_irq));
    in_valid = v;
    in_data  = d;
    tail_we  = tw;
    tail_idx = IW'(tv);
    acc      = v && !mfull;
    exp_irq  = exp_wr;
    exp_wr   = acc;
    if (acc) begin
      exp_addr = mh;
      exp_data = stamp_fn(d, ml);
      exp_err  = d[ERR];
      if (mh == D - 1) begin
        mh = 0;
        ml = (ml + 1) % 16;
      end else begin
        mh = mh + 1;
      end
    end
    if (tw) mt = tv;
  endtask

  function automatic logic [EW-1:0] rnd_entry(input bit err);
    logic [EW-1:0] r;
    for (int i = 0; i < EW / 32; i++) r[i*32 +: 32] = $urandom;
    r[ERR] = err;
    return r;
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    tail_we  = 1'b0;
    tail_idx = '0;
    mh = 0; mt = 0; ml = 0;
    exp_wr = 0; exp_irq = 0; exp_addr = 0; exp_data = '0; exp_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(head_idx == '0, "R1", "head after reset", EW'(head_idx), '0);
    chk(full == 1'b0, "R1", "full after reset", EW'(full), '0);
    chk(in_ready == 1'b1, "R1", "ready after reset", EW'(in_ready), EW'(1));
    chk(wr_en == 1'b0, "R1", "wr_en after reset", EW'(wr_en), '0);
    chk(irq == 1'b0, "R1", "irq after reset", EW'(irq), '0);
    rst_n = 1'b1;

    // R3: fill against tail 0 until full, keep offering
    for (int i = 0; i < 20; i++) cycle(1'b1, rnd_entry(1'b0), 1'b0, 0);
    // R4: move tail while full and offering in the same cycle
    cycle(1'b1, rnd_entry(1'b0), 1'b1, 8);
    cycle(1'b1, rnd_entry(1'b0), 1'b0, 0);
    // R6/R7: wrap with an error entry at the last slot, then clean entries
    cycle(1'b0, '0, 1'b1, 15);
    while (mh != D - 1) cycle(1'b1, rnd_entry(1'b0), 1'b1, (mh + 2) % D);
    cycle(1'b1, rnd_entry(1'b1), 1'b1, 3);
    for (int i = 0; i < 4; i++) cycle(1'b1, rnd_entry(1'b0), 1'b0, 0);
    cycle(1'b0, '0, 1'b0, 0);

    // random phase, enough passes to wrap the pass counter many times
    for (int i = 0; i < 6000; i++) begin
      bit v, tw, er;
      int tv;
      v  = ($urandom % 4) != 0;
      er = ($urandom % 8) == 0;
      tw = ($urandom % 3) == 0;
      tv = (mh + D - int'($urandom % 4)) % D;
      cycle(v, rnd_entry(er), tw, tv);
    end
    cycle(1'b0, '0, 1'b0, 0);
    cycle(1'b0, '0, 1'b0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule